// File: doc/BRIEF.md
# Segmented Memory Address Generator

This block forms 20-bit physical byte addresses for a 1 MB space. Each address is a 16-bit segment base plus a 16-bit offset. It holds four 16-bit segment bases with fixed roles: code, data, stack and extra data. Each base can be loaded through a write port. It also owns an instruction pointer and a stack pointer. A request names an access kind. The kind picks a default segment and an offset source: the external offset input (a base, pointer or index register value), the instruction pointer, or the stack pointer. Pushes and pops step the stack pointer so that the stack grows toward lower addresses.

The result is registered and appears with a valid strobe one clock after the request. The physical address is the segment value shifted left by four bits plus the offset, truncated to 20 bits. A segment-override input can redirect data accesses only.

Top module: `seg_addr_gen`

## Requirements
- R1: A synchronous reset clears the data, stack and extra segments, the stack pointer and the instruction pointer to 0. It sets the code segment to 16'hFFFF. `addrValid` is low after reset, and the first fetch yields 20'hFFFF0.
- R2: The address is (segment << 4) + offset. It is registered and appears on `physAddr` with `addrValid` high one clock after the request is sampled.
- R3: Any carry beyond bit 19 is dropped, so addresses wrap within 1 MB. For example, segment 16'hFFFF with offset 16'h0010 gives 20'h00000.
- R4: A fetch (`reqKind` 0) uses the code segment with the instruction pointer as offset, then adds 1 to the instruction pointer.
- R5: A data access (`reqKind` 1) uses the data segment and an alternate data access (`reqKind` 2) uses the extra segment, both with `reqOffset` as offset. `addrSeg` reports the segment used, coded as 0 code, 1 data, 2 stack, 3 extra.
- R6: When `ovrValid` is high, the segment coded on `ovrSel` replaces the default for kinds 1 and 2. For fetches, pushes and pops the override has no effect.
- R7: A push (`reqKind` 3) first lowers the stack pointer by 2 and then presents stack segment : new stack pointer, in the same clock.
- R8: A pop (`reqKind` 4) presents stack segment : stack pointer and then raises the stack pointer by 2. Pops return push addresses in reverse order.
- R9: Pointer stepping wraps modulo 65536 and never carries into the segment. An instruction pointer of 16'hFFFF becomes 0, and a push from a stack pointer of 0 gives 16'hFFFE.
- R10: A segment write in the same cycle as a request takes effect from the next request. The current request uses the old base.
- R11: A pointer write (`ptrWrSel` 0 instruction pointer, 1 stack pointer) loads the pointer. It takes priority over any step in the same cycle.
- R12: Without a request, or with `reqKind` 5 to 7, `addrValid` is low on the next clock and no pointer moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| segWrEn | input | 1 | Segment base write enable |
| segWrSel | input | 2 | Segment to write (0 code, 1 data, 2 stack, 3 extra) |
| segWrData | input | 16 | New segment base |
| ptrWrEn | input | 1 | Pointer write enable |
| ptrWrSel | input | 1 | 0 instruction pointer, 1 stack pointer |
| ptrWrData | input | 16 | New pointer value |
| reqValid | input | 1 | Request strobe |
| reqKind | input | 3 | 0 fetch, 1 data, 2 alternate data, 3 push, 4 pop |
| reqOffset | input | 16 | External offset for data kinds |
| ovrValid | input | 1 | Segment override present |
| ovrSel | input | 2 | Override segment code |
| addrValid | output | 1 | Physical address valid |
| physAddr | output | 20 | Physical byte address |
| addrSeg | output | 2 | Segment used for the address |
| ipValue | output | 16 | Current instruction pointer |
| spValue | output | 16 | Current stack pointer |

## Verification
The bench goes after the wrap at the top of the 1 MB space. A design that kept a 21st bit or carried the offset into the segment would give an address above 20'hFFFFF or a shifted one. It also drives pushes and pops from a stack pointer of 0 and a fetch at an instruction pointer of 16'hFFFF. A post-decrementing push, or a pointer that leaks into the segment, would show the wrong address or pointer there. Overrides are sent with fetches and pushes, so a design that applied them everywhere would report the wrong segment. A segment write issued together with a request exposes a base that is forwarded too early.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } seg_e;

  typedef enum logic [2:0] {
    KIND_FETCH = 3'd0,
    KIND_DATA  = 3'd1,
    KIND_ALT   = 3'd2,
    KIND_PUSH  = 3'd3,
    KIND_POP   = 3'd4
  } kind_e;

  typedef enum logic [1:0] {
    OFF_EXT   = 2'd0,
    OFF_IP    = 2'd1,
    OFF_SPDEC = 2'd2,
    OFF_SP    = 2'd3
  } off_e;

  typedef struct packed {
    logic load;
    seg_e segSel;
    off_e offSrc;
    logic ipInc;
    logic spDec;
    logic spInc;
  } strobe_t;

endpackage

// File: rtl/seg_addr_ctrl.sv
module seg_addr_ctrl
  import seg_addr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic [2:0] reqKind,
  input  logic       ovrValid,
  input  logic [1:0] ovrSel,
  output strobe_t    strobes
);

  always_comb begin
    strobes = '{load: 1'b0, segSel: SEG_DATA, offSrc: OFF_EXT,
                ipInc: 1'b0, spDec: 1'b0, spInc: 1'b0};
    if (reqValid) begin
      case (reqKind)
        KIND_FETCH: begin
          strobes.load   = 1'b1;
          strobes.segSel = SEG_CODE;
          strobes.offSrc = OFF_IP;
          strobes.ipInc  = 1'b1;
        end
        KIND_DATA: begin
          strobes.load   = 1'b1;
          strobes.segSel = ovrValid ? seg_e'(ovrSel) : SEG_DATA;
        end
        KIND_ALT: begin
          strobes.load   = 1'b1;
          strobes.segSel = ovrValid ? seg_e'(ovrSel) : SEG_EXTRA;
        end
        KIND_PUSH: begin
          strobes.load   = 1'b1;
          strobes.segSel = SEG_STACK;
          strobes.offSrc = OFF_SPDEC;
          strobes.spDec  = 1'b1;
        end
        KIND_POP: begin
          strobes.load   = 1'b1;
          strobes.segSel = SEG_STACK;
          strobes.offSrc = OFF_SP;
          strobes.spInc  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R6: override never reaches code fetches
  a_r6_fetch_ignores_override: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqKind == 3'd0) |-> strobes.segSel == SEG_CODE);

  // R6: stack kinds always use the stack segment
  a_r6_stack_ignores_override: assert property (@(posedge clk) disable iff (rst)
    (reqValid && (reqKind == 3'd3 || reqKind == 3'd4)) |-> strobes.segSel == SEG_STACK);

  // R12: unknown kinds produce no load
  a_r12_no_load_bad_kind: assert property (@(posedge clk) disable iff (rst)
    (reqKind > 3'd4) |-> !strobes.load);

  // R4: at most one pointer step per cycle
  a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.ipInc, strobes.spDec, strobes.spInc}));

endmodule

// File: rtl/seg_addr_dp.sv
module seg_addr_dp
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int SHIFT = 4,
  parameter int NUM_SEG = 4,
  parameter int STACK_STEP = 2,
  parameter logic [SEG_W-1:0] RESET_CODE = 16'hFFFF,
  localparam int PHYS_W = SEG_W + SHIFT,
  localparam int SEL_W = $clog2(NUM_SEG)
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobes,
  input  logic [SEG_W-1:0]  reqOffset,
  input  logic              segWrEn,
  input  logic [SEL_W-1:0]  segWrSel,
  input  logic [SEG_W-1:0]  segWrData,
  input  logic              ptrWrEn,
  input  logic              ptrWrSel,
  input  logic [SEG_W-1:0]  ptrWrData,
  output logic              addrValid,
  output logic [PHYS_W-1:0] physAddr,
  output logic [SEL_W-1:0]  addrSeg,
  output logic [SEG_W-1:0]  ipValue,
  output logic [SEG_W-1:0]  spValue
);

  localparam logic [SEG_W-1:0] STEP = SEG_W'(STACK_STEP);

  logic [SEG_W-1:0]   segReg [NUM_SEG];
  logic [NUM_SEG-1:0] segHit;
  logic [SEG_W-1:0]   ipReg, spReg, offVal, segBase;
  logic [PHYS_W-1:0]  physNext;

  for (genvar g = 0; g < NUM_SEG; g++) begin : gHit
    assign segHit[g] = segWrEn && (segWrSel == SEL_W'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SEG; i++) begin
      if (rst)
        segReg[i] <= (i == int'(SEG_CODE)) ? RESET_CODE : '0;
      else if (segHit[i])
        segReg[i] <= segWrData;
    end
  end

  always_comb begin
    case (strobes.offSrc)
      OFF_IP:    offVal = ipReg;
      OFF_SPDEC: offVal = spReg - STEP;
      OFF_SP:    offVal = spReg;
      default:   offVal = reqOffset;
    endcase
    segBase  = segReg[strobes.segSel];
    physNext = {segBase, SHIFT'(0)} + PHYS_W'(offVal);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ipReg <= '0;
      spReg <= '0;
    end else begin
      if (ptrWrEn && !ptrWrSel)   ipReg <= ptrWrData;
      else if (strobes.ipInc)     ipReg <= ipReg + SEG_W'(1);
      if (ptrWrEn && ptrWrSel)    spReg <= ptrWrData;
      else if (strobes.spDec)     spReg <= spReg - STEP;
      else if (strobes.spInc)     spReg <= spReg + STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addrValid <= 1'b0;
      physAddr  <= '0;
      addrSeg   <= '0;
    end else begin
      addrValid <= strobes.load;
      if (strobes.load) begin
        physAddr <= physNext;
        addrSeg  <= SEL_W'(strobes.segSel);
      end
    end
  end

  assign ipValue = ipReg;
  assign spValue = spReg;

  // R7: push lowers the stack pointer by the step
  a_r7_push_step: assert property (@(posedge clk) disable iff (rst)
    (strobes.spDec && !(ptrWrEn && ptrWrSel)) |=> spReg == $past(spReg) - STEP);

  // R8: pop raises the stack pointer by the step
  a_r8_pop_step: assert property (@(posedge clk) disable iff (rst)
    (strobes.spInc && !(ptrWrEn && ptrWrSel)) |=> spReg == $past(spReg) + STEP);

  // R4: fetch advances the instruction pointer by one
  a_r4_ip_step: assert property (@(posedge clk) disable iff (rst)
    (strobes.ipInc && !(ptrWrEn && !ptrWrSel)) |=> ipReg == $past(ipReg) + SEG_W'(1));

  // R2: valid strobe follows a load by one clock
  a_r2_valid_after_load: assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> addrValid);

  // R12: no load means no valid and no pointer motion
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!strobes.load && !ptrWrEn) |=> (!addrValid && $stable(spReg) && $stable(ipReg)));

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int SHIFT = 4,
  parameter int NUM_SEG = 4,
  parameter int STACK_STEP = 2,
  localparam int PHYS_W = SEG_W + SHIFT,
  localparam int SEL_W = $clog2(NUM_SEG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              segWrEn,
  input  logic [SEL_W-1:0]  segWrSel,
  input  logic [SEG_W-1:0]  segWrData,
  input  logic              ptrWrEn,
  input  logic              ptrWrSel,
  input  logic [SEG_W-1:0]  ptrWrData,
  input  logic              reqValid,
  input  logic [2:0]        reqKind,
  input  logic [SEG_W-1:0]  reqOffset,
  input  logic              ovrValid,
  input  logic [SEL_W-1:0]  ovrSel,
  output logic              addrValid,
  output logic [PHYS_W-1:0] physAddr,
  output logic [SEL_W-1:0]  addrSeg,
  output logic [SEG_W-1:0]  ipValue,
  output logic [SEG_W-1:0]  spValue
);

  strobe_t strobes;

  seg_addr_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .ovrValid (ovrValid),
    .ovrSel   (ovrSel),
    .strobes  (strobes)
  );

  seg_addr_dp #(
    .SEG_W      (SEG_W),
    .SHIFT      (SHIFT),
    .NUM_SEG    (NUM_SEG),
    .STACK_STEP (STACK_STEP)
  ) uDp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .reqOffset (reqOffset),
    .segWrEn   (segWrEn),
    .segWrSel  (segWrSel),
    .segWrData (segWrData),
    .ptrWrEn   (ptrWrEn),
    .ptrWrSel  (ptrWrSel),
    .ptrWrData (ptrWrData),
    .addrValid (addrValid),
    .physAddr  (physAddr),
    .addrSeg   (addrSeg),
    .ipValue   (ipValue),
    .spValue   (spValue)
  );

endmodule

// File: tb/seg_addr_gen_test.sv
`timescale 1ns/1ps
module seg_addr_gen_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        segWrEn = 1'b0;
  logic [1:0]  segWrSel = '0;
  logic [15:0] segWrData = '0;
  logic        ptrWrEn = 1'b0;
  logic        ptrWrSel = 1'b0;
  logic [15:0] ptrWrData = '0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqKind = '0;
  logic [15:0] reqOffset = '0;
  logic        ovrValid = 1'b0;
  logic [1:0]  ovrSel = '0;
  logic        addrValid;
  logic [19:0] physAddr;
  logic [1:0]  addrSeg;
  logic [15:0] ipValue, spValue;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [19:0] expAddrQ [$];
  logic [1:0]  expSegQ [$];
  string       expTagQ [$];

  logic [15:0] mSeg [4];
  logic [15:0] mIp, mSp;

  always #2.5 clk = ~clk;

  seg_addr_gen uut (
    .clk(clk), .rst(rst),
    .segWrEn(segWrEn), .segWrSel(segWrSel), .segWrData(segWrData),
    .ptrWrEn(ptrWrEn), .ptrWrSel(ptrWrSel), .ptrWrData(ptrWrData),
    .reqValid(reqValid), .reqKind(reqKind), .reqOffset(reqOffset),
    .ovrValid(ovrValid), .ovrSel(ovrSel),
    .addrValid(addrValid), .physAddr(physAddr), .addrSeg(addrSeg),
    .ipValue(ipValue), .spValue(spValue)
  );

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    logic [20:0] full;
    full = {1'b0, s, 4'h0} + {5'h0, o};
    return full[19:0];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard entries as addresses appear
  always @(posedge clk) begin
    #1;
    if (!rst && addrValid) begin
      if (expAddrQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R12 unexpected address actual=%h expected=none", physAddr);
      end else begin
        string t;
        t = expTagQ.pop_front();
        check(t, {12'h0, physAddr}, {12'h0, expAddrQ.pop_front()});
        check(t, {30'h0, addrSeg}, {30'h0, expSegQ.pop_front()});
      end
    end
  end

  // driver: one request per call, called at a falling edge
  task automatic req(input logic [2:0] kind, input logic [15:0] off,
                     input logic ov, input logic [1:0] os, input string tag);
    logic [1:0]  s;
    logic [15:0] o;
    reqValid = 1'b1; reqKind = kind; reqOffset = off; ovrValid = ov; ovrSel = os;
    case (kind)
      3'd0: begin s = 2'd0; o = mIp; mIp = mIp + 16'd1; end
      3'd1: begin s = ov ? os : 2'd1; o = off; end
      3'd2: begin s = ov ? os : 2'd3; o = off; end
      3'd3: begin s = 2'd2; mSp = mSp - 16'd2; o = mSp; end
      default: begin s = 2'd2; o = mSp; mSp = mSp + 16'd2; end
    endcase
    expAddrQ.push_back(phys(mSeg[s], o));
    expSegQ.push_back(s);
    expTagQ.push_back(tag);
    if (segWrEn) mSeg[segWrSel] = segWrData;
    @(negedge clk);
    reqValid = 1'b0; ovrValid = 1'b0; segWrEn = 1'b0;
  endtask

  task automatic segWrite(input logic [1:0] sel, input logic [15:0] val);
    segWrEn = 1'b1; segWrSel = sel; segWrData = val;
    mSeg[sel] = val;
    @(negedge clk);
    segWrEn = 1'b0;
  endtask

  task automatic ptrWrite(input logic sel, input logic [15:0] val);
    ptrWrEn = 1'b1; ptrWrSel = sel; ptrWrData = val;
    if (sel) mSp = val; else mIp = val;
    @(negedge clk);
    ptrWrEn = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    mSeg[0] = 16'hFFFF; mSeg[1] = '0; mSeg[2] = '0; mSeg[3] = '0;
    mIp = '0; mSp = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 valid", {31'h0, addrValid}, 32'h0);
    check("R1 ip", {16'h0, ipValue}, 32'h0);
    check("R1 sp", {16'h0, spValue}, 32'h0);
    // R1/R4: first fetches from FFFF0
    req(3'd0, 16'h0, 1'b0, 2'd0, "R1 first fetch");
    req(3'd0, 16'h0, 1'b0, 2'd0, "R4 second fetch");
    check("R4 ip step", {16'h0, ipValue}, {16'h0, mIp});
    // R2/R5: data and alternate data
    segWrite(2'd1, 16'h1234);
    segWrite(2'd3, 16'h0A00);
    req(3'd1, 16'h0056, 1'b0, 2'd0, "R2 data addr");
    req(3'd2, 16'hBEEF, 1'b0, 2'd0, "R5 extra addr");
    // R3: wrap within 1 MB
    segWrite(2'd1, 16'hFFFF);
    req(3'd1, 16'h0010, 1'b0, 2'd0, "R3 wrap 1MB");
    req(3'd1, 16'hFFFF, 1'b0, 2'd0, "R3 wrap high");
    // R9: stack wrap from SP 0 (stack segment still 0)
    req(3'd3, 16'h0, 1'b0, 2'd0, "R9 push from zero");
    check("R9 sp wrap", {16'h0, spValue}, 32'h0000FFFE);
    req(3'd4, 16'h0, 1'b0, 2'd0, "R9 pop to zero");
    check("R9 sp back", {16'h0, spValue}, 32'h0);
    // R6: override on data kinds, ignored on fetch and stack kinds
    segWrite(2'd2, 16'h3000);
    req(3'd1, 16'h0004, 1'b1, 2'd2, "R6 data override stack");
    req(3'd2, 16'h0008, 1'b1, 2'd0, "R6 alt override code");
    req(3'd0, 16'h0, 1'b1, 2'd3, "R6 fetch ignores override");
    // R11/R7/R8: load SP, push twice, pop twice
    ptrWrite(1'b1, 16'h0100);
    check("R11 sp load", {16'h0, spValue}, 32'h00000100);
    req(3'd3, 16'h0, 1'b1, 2'd1, "R7 push one");
    check("R7 sp after push", {16'h0, spValue}, 32'h000000FE);
    req(3'd3, 16'h0, 1'b0, 2'd0, "R7 push two");
    req(3'd4, 16'h0, 1'b1, 2'd3, "R8 pop two");
    req(3'd4, 16'h0, 1'b0, 2'd0, "R8 pop one");
    check("R8 sp restored", {16'h0, spValue}, 32'h00000100);
    // R9: IP wrap
    ptrWrite(1'b0, 16'hFFFF);
    req(3'd0, 16'h0, 1'b0, 2'd0, "R9 fetch at top");
    check("R9 ip wrap", {16'h0, ipValue}, 32'h0);
    // R10: same-cycle segment write uses old base for this request
    segWrEn = 1'b1; segWrSel = 2'd1; segWrData = 16'h2000;
    req(3'd1, 16'h0001, 1'b0, 2'd0, "R10 old base");
    req(3'd1, 16'h0001, 1'b0, 2'd0, "R10 new base");
    // R11: pointer write beats a push step in the same cycle
    ptrWrEn = 1'b1; ptrWrSel = 1'b1; ptrWrData = 16'h0400;
    req(3'd3, 16'h0, 1'b0, 2'd0, "R11 push with load");
    ptrWrEn = 1'b0; mSp = 16'h0400;
    check("R11 load wins", {16'h0, spValue}, 32'h00000400);
    // R12: idle and unknown kinds
    @(negedge clk);
    check("R12 idle valid", {31'h0, addrValid}, 32'h0);
    reqValid = 1'b1; reqKind = 3'd6;
    @(negedge clk);
    reqValid = 1'b0;
    check("R12 bad kind valid", {31'h0, addrValid}, 32'h0);
    check("R12 bad kind sp", {16'h0, spValue}, 32'h00000400);
    check("R12 bad kind ip", {16'h0, ipValue}, {16'h0, mIp});
    repeat (2) @(negedge clk);
    check("R2 scoreboard drained", expAddrQ.size(), 32'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule